// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of a parallel disk interface's register file. A host reaches eight byte-wide registers through a simple read/write port with a 3-bit offset. The block keeps the sector-count, three address bytes, device-select, error and status registers. It drives an interrupt line and runs a small set of commands.

Three kinds of command are handled. An identify command streams 256 parameter words out of the data port under DRQ. A flush command holds the device busy for a configurable number of cycles. Every other opcode is aborted at once and reports an error. Reads of the status register acknowledge the interrupt. Reads of the data port step through the parameter words.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status register (offset 7) reads 0x40, the error register (offset 1) reads 0x00, offsets 2 to 6 read 0x00 and irq is low.
- R2: Offsets 2 (sector count), 3, 4, 5 (address bytes) and 6 (device) read back the last byte written to them. Writing 0x40 to offset 6 selects device 0, and the readback has bit 4 (0x10) clear.
- R3: Writing 0xEC to offset 7 starts identify. During each of the 256 word reads at offset 0, status reads 0x48 (DRDY|DRQ; BSY, DF and ERR clear). Word i returns {~i[7:0], i[7:0]}, except word 85, which returns 0x0020 (bit 5 set, write cache enabled).
- R4: After the 256th data read, status reads 0x40 (DRQ clear, DRDY set). Offset 0 reads 0x0000 while DRQ is clear.
- R5: irq rises when identify data becomes ready, when a flush completes and when a command aborts. A status read lowers it at the next clock edge. A read of the error register leaves it set.
- R6: Writing 0xE7 to offset 7 starts a flush. Status reads 0xC0 (BSY|DRDY) for FLUSH_CYCLES clock edges after the command edge, then 0x40.
- R7: Any opcode other than 0xEC or 0xE7 completes at the next edge. Status then reads 0x41 (ERR set), the error register reads 0x04 (abort) and irq is raised.
- R8: A write to offset 7 while BSY is set is ignored. An identify written during a flush leaves status at 0x40 with no DRQ once the flush ends.
- R9: An accepted identify or flush command clears ERR in status and clears the error register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| rd_data | output | 16 | Read data for the addressed register, combinational from addr |
| irq | output | 1 | Interrupt request |

## Verification
A word pointer that is off by one shows up at the ports in two ways. It returns the wrong parameter word on the very read where it slips. It also makes DRQ drop a read early or late at the end of the 256-word stream, and the status read after the last word catches that. A busy counter that is wrong shows as BSY clearing one cycle away from FLUSH_CYCLES; the bench samples status at both neighbouring cycles. An interrupt flag that fails to clear, or clears on the wrong register, is visible on irq one cycle after the read.

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl #(
  parameter int FLUSH_CYCLES = 16,
  parameter int ID_WORDS     = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        irq
);
  localparam int IW = $clog2(ID_WORDS);
  localparam int CW = $clog2(FLUSH_CYCLES + 1);
  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;

  logic          bsy, drq, err, irq_q;
  logic [7:0]    err_reg, nsect, lba_lo, lba_mid, lba_hi, dev_reg;
  logic [CW-1:0] cnt;
  logic [IW-1:0] widx;
  logic [7:0]    status;

  function automatic logic [15:0] id_word(input logic [IW-1:0] i);
    logic [7:0] b;
    b = 8'(i);
    if (i == IW'(85)) return 16'h0020;
    return {~b, b};
  endfunction

  assign status = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};
  assign irq    = irq_q;

  wire cmd_wr  = wr_en && addr == 3'd7 && !bsy;
  wire stat_rd = rd_en && addr == 3'd7;
  wire data_rd = rd_en && addr == 3'd0 && drq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy <= 1'b0; drq <= 1'b0; err <= 1'b0; irq_q <= 1'b0;
      err_reg <= '0; nsect <= '0; lba_lo <= '0; lba_mid <= '0;
      lba_hi <= '0; dev_reg <= '0; cnt <= '0; widx <= '0;
    end else begin
      if (stat_rd) irq_q <= 1'b0;
      if (data_rd) begin
        widx <= widx + 1'b1;
        if (widx == IW'(ID_WORDS - 1)) drq <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          3'd2: nsect   <= wr_data;
          3'd3: lba_lo  <= wr_data;
          3'd4: lba_mid <= wr_data;
          3'd5: lba_hi  <= wr_data;
          3'd6: dev_reg <= wr_data;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        case (wr_data)
          OP_IDENT: begin
            drq <= 1'b1; err <= 1'b0; err_reg <= '0;
            widx <= '0; irq_q <= 1'b1;
          end
          OP_FLUSH: begin
            bsy <= 1'b1; cnt <= CW'(FLUSH_CYCLES);
            drq <= 1'b0; err <= 1'b0; err_reg <= '0;
          end
          default: begin
            err <= 1'b1; err_reg <= 8'h04; drq <= 1'b0; irq_q <= 1'b1;
          end
        endcase
      end else if (bsy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          bsy   <= 1'b0;
          irq_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = drq ? id_word(widx) : 16'h0000;
      3'd1:    rd_data = {8'h00, err_reg};
      3'd2:    rd_data = {8'h00, nsect};
      3'd3:    rd_data = {8'h00, lba_lo};
      3'd4:    rd_data = {8'h00, lba_mid};
      3'd5:    rd_data = {8'h00, lba_hi};
      3'd6:    rd_data = {8'h00, dev_reg};
      default: rd_data = {8'h00, status};
    endcase
  end
endmodule

// File: rtl/ata_taskfile_ctrl_chk.sv
module ata_taskfile_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic       bsy,
  input logic       drq,
  input logic       err,
  input logic       irq
);
  p_bsy_drq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  p_drq_fall_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> $past(rd_en && addr == 3'd0));

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd7 && !wr_en && !bsy) |=> !irq);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7 && !bsy && wr_data != 8'hEC && wr_data != 8'hE7)
      |=> (err && irq && !drq));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && wr_en && addr == 3'd7) |=> !drq);
endmodule

bind ata_taskfile_ctrl ata_taskfile_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .bsy(bsy), .drq(drq), .err(err), .irq(irq_q)
);

// File: tb/test_ata_taskfile_ctrl.sv
module test_ata_taskfile_ctrl;
  localparam int FC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  ata_taskfile_ctrl #(.FLUSH_CYCLES(FC), .ID_WORDS(256)) i_ata_taskfile_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  localparam logic [10:0] VEC [0:9] = '{
    {3'd2, 8'h01}, {3'd3, 8'h5A}, {3'd4, 8'hC3}, {3'd5, 8'h7E}, {3'd6, 8'h40},
    {3'd2, 8'hFF}, {3'd3, 8'h00}, {3'd4, 8'h81}, {3'd5, 8'h24}, {3'd6, 8'h50}};

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1 d = rd_data;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    logic [7:0] b;
    b = 8'(i);
    if (i == 85) return 16'h0020;
    return {~b, b};
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    peek(3'd7, v); chk("R1 status", v, 16'h0040);
    peek(3'd1, v); chk("R1 error", v, 16'h0000);
    for (int a = 2; a <= 6; a++) begin
      peek(3'(a), v); chk("R1 reg", v, 16'h0000);
    end
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 register readback from vector table
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][10:8], VEC[i][7:0]);
      rd(VEC[i][10:8], v);
      chk("R2 readback", v, {8'h00, VEC[i][7:0]});
    end
    wr(3'd6, 8'h40);
    rd(3'd6, v); chk("R2 dev bit4", v & 16'h0010, 16'h0000);

    // R7 abort, R5 error read keeps irq
    wr(3'd7, 8'h12);
    peek(3'd7, v); chk("R7 status", v, 16'h0041);
    chk("R7 irq", {15'd0, irq}, 16'd1);
    rd(3'd1, v); chk("R7 error", v, 16'h0004);
    chk("R5 irq kept by error read", {15'd0, irq}, 16'd1);
    rd(3'd7, v); chk("R5 status read", v, 16'h0041);
    chk("R5 irq cleared", {15'd0, irq}, 16'd0);

    // R3 identify stream, R9 clears error
    wr(3'd7, 8'hEC);
    chk("R5 irq on identify", {15'd0, irq}, 16'd1);
    rd(3'd1, v); chk("R9 error cleared", v, 16'h0000);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, v); chk("R3 status", v, 16'h0048);
      if (i == 0) chk("R5 irq cleared identify", {15'd0, irq}, 16'd0);
      rd(3'd0, v); chk("R3 word", v, exp_word(i));
      if (i == 85) chk("R3 word85 bit5", v & 16'h0020, 16'h0020);
    end
    rd(3'd7, v); chk("R4 status after last", v, 16'h0040);
    rd(3'd0, v); chk("R4 data idle", v, 16'h0000);

    // R6 flush exact timing
    wr(3'd7, 8'hE7);
    peek(3'd7, v); chk("R6 busy", v, 16'h00C0);
    repeat (FC - 1) @(negedge clk);
    peek(3'd7, v); chk("R6 busy last cycle", v, 16'h00C0);
    chk("R6 no irq yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    peek(3'd7, v); chk("R6 done", v, 16'h0040);
    chk("R5 irq on flush", {15'd0, irq}, 16'd1);
    rd(3'd7, v);
    chk("R5 irq cleared flush", {15'd0, irq}, 16'd0);

    // R8 command ignored while busy
    wr(3'd7, 8'hE7);
    wr(3'd7, 8'hEC);
    wr(3'd7, 8'h00);
    repeat (FC + 2) @(negedge clk);
    rd(3'd7, v); chk("R8 status after ignored", v, 16'h0040);
    rd(3'd1, v); chk("R8 error after ignored", v, 16'h0000);
    rd(3'd0, v); chk("R8 no data", v, 16'h0000);

    // R9 flush clears prior abort
    wr(3'd7, 8'hFF);
    rd(3'd7, v); chk("R9 abort set", v, 16'h0041);
    wr(3'd7, 8'hE7);
    peek(3'd7, v); chk("R9 err cleared busy", v, 16'h00C0);
    repeat (FC + 2) @(negedge clk);
    rd(3'd7, v); chk("R9 flush final", v, 16'h0040);
    rd(3'd1, v); chk("R9 error reg", v, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule